// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one raw NAND flash operation. The operation is described by a set of latched values and a 16-bit enable mask. The values are three opcodes, a 16-bit column, a 24-bit row and a transfer length. Each mask bit turns on one kind of bus cycle. A start pulse captures everything. The sequencer then issues the enabled phases in a fixed priority order, highest bit first, and skips every phase whose bit is clear. Command cycles raise CLE and address cycles raise ALE. Data phases move bytes between the flash bus and an internal word-wide page buffer. The ready/busy phase stalls until the device reports ready.

The page buffer has a host port, one 32-bit word at a time, and an engine port that moves one or two bytes per bus cycle. Bytes sit big-endian inside each word, so the first byte on the bus lands in the top byte of word 0. A width select picks an 8-bit or 16-bit bus for the page data phases. Command, address, status and identification cycles always use the low byte lane. When the operation ends, a sticky done flag is raised. An error flag is also raised if the device stayed busy for too long.

Top module: `nand_seq`

## Requirements
- R1: After reset the block is idle: `we_no` and `re_no` high, `cle_o`, `ale_o`, `io_oe_o`, `busy_o`, `done_o` and `err_o` low.
- R2: Mask bit map: 14 opcode A, 13 column low, 12 column high, 11 row low, 10 row middle, 9 row high, 8 write data, 7 opcode B, 6 ready wait, 5 read data, 4 opcode C, 3 status read, 2 identification read. Bits 15, 1 and 0 are ignored. Enabled phases run from the highest bit to the lowest, and clear bits produce no bus cycle.
- R3: Opcode phases put their byte on `io_o[7:0]` with `cle_o` high. Address phases do the same with `ale_o` high. `cle_o` and `ale_o` are never high together, and neither is high during data cycles.
- R4: The address byte sent for bit 13 is `col_i[7:0]` and for bit 12 is `col_i[15:8]`. Bits 11, 10 and 9 send `row_i[7:0]`, `row_i[15:8]` and `row_i[23:16]`.
- R5: The write data phase sends `xfer_len_i` bytes from the buffer. Byte n comes from word n/4, bits 31-8*(n%4) down to 24-8*(n%4). A length of zero produces no bus cycle.
- R6: The read data phase captures `xfer_len_i` bytes from `io_i` on each rising edge of `re_no`. They are stored with the same big-endian packing as in R5.
- R7: With `wide_i` high, each data cycle moves two bytes: `io[7:0]` carries the earlier byte and `io[15:8]` the next one. Opcode and address cycles drive `io_o[15:8]` to zero.
- R8: The status read (bit 3) stores one byte, taken from `io_i[7:0]`, into buffer byte 0 and leaves the other bytes of that word unchanged. The identification read (bit 2) stores `xfer_len_i` bytes into the buffer from byte 0, one byte per cycle, even when `wide_i` is high.
- R9: The ready wait phase holds off the following phases until `rb_ni` is sampled high.
- R10: If `rb_ni` stays low for `TIMEOUT_CYC` clocks of the wait phase, every remaining phase is dropped, and `err_o` and `done_o` are set.
- R11: A start pulse while `busy_o` is high is ignored and does not alter the running operation.
- R12: `done_o` is set one clock after the last phase ends. It stays set until the next accepted start, which clears both `done_o` and `err_o`.
- R13: Each `we_no` or `re_no` low pulse lasts exactly `T_LO` clocks. The strobe then stays high for at least `T_HI` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| code_i | input | 16 | Phase enable mask |
| cmd1_i | input | 8 | Opcode A |
| cmd2_i | input | 8 | Opcode B |
| cmd3_i | input | 8 | Opcode C |
| col_i | input | 16 | Column address |
| row_i | input | 24 | Row address |
| xfer_len_i | input | 12 | Data phase length in bytes |
| wide_i | input | 1 | 16-bit bus for page data phases |
| buf_we_i | input | 1 | Host buffer word write |
| buf_addr_i | input | 10 | Host buffer word address |
| buf_wdata_i | input | 32 | Host buffer write word |
| buf_rdata_o | output | 32 | Host buffer read word |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_o | output | 16 | Flash bus output data |
| io_oe_o | output | 1 | Flash bus output enable |
| io_i | input | 16 | Flash bus input data |
| rb_ni | input | 1 | Ready (high) / busy (low) from the device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Sticky completion flag |
| err_o | output | 1 | Sticky busy-timeout flag |

## Verification
The most delicate overlap is a new start request that arrives in the same clock in which the final phase retires and the done flag rises. The bench keeps `start_i` high, with a different mask and opcode, on every clock while `busy_o` is high. That includes the edge at which the block returns to idle. The run passes if `done_o` is still set afterwards and stays set a cycle later. The flash-side log must also show only the bus cycles of the first operation, with no trace of the second opcode.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int CODE_W = 16;
  localparam logic [3:0] B_CMD1 = 4'd14;
  localparam logic [3:0] B_COL0 = 4'd13;
  localparam logic [3:0] B_COL1 = 4'd12;
  localparam logic [3:0] B_ROW0 = 4'd11;
  localparam logic [3:0] B_ROW1 = 4'd10;
  localparam logic [3:0] B_ROW2 = 4'd9;
  localparam logic [3:0] B_WDAT = 4'd8;
  localparam logic [3:0] B_CMD2 = 4'd7;
  localparam logic [3:0] B_RBW  = 4'd6;
  localparam logic [3:0] B_RDAT = 4'd5;
  localparam logic [3:0] B_CMD3 = 4'd4;
  localparam logic [3:0] B_STAT = 4'd3;
  localparam logic [3:0] B_ID   = 4'd2;
  localparam logic [CODE_W-1:0] CODE_MASK = 16'h7FFC;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} seq_st_e;

  typedef struct packed {
    logic cmd;
    logic addr;
    logic wr;
    logic rd;
    logic stat;
    logic id;
    logic rbw;
  } ph_kind_t;
endpackage

// File: rtl/nand_seq_pick.sv
module nand_seq_pick #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // highest set bit wins: later iterations override earlier ones
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
  parameter int T_LO = 2,
  parameter int T_HI = 2,
  localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI,
  localparam int CW = $clog2(TMAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic low_o,
  output logic sample_o,
  output logic end_o,
  output logic busy_o
);
  logic          act_q, lo_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      lo_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (go_i) begin
        act_q <= 1'b1;
        lo_q  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (lo_q) begin
      if (cnt_q == CW'(T_LO - 1)) begin
        lo_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == CW'(T_HI - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign low_o    = act_q & lo_q;
  assign sample_o = act_q & lo_q & (cnt_q == CW'(T_LO - 1));
  assign end_o    = act_q & ~lo_q & (cnt_q == CW'(T_HI - 1));
  assign busy_o   = act_q;

  // R13
  low_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(low_o) |-> $past(sample_o));
endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int WORDS = 528,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [31:0]   host_wdata_i,
  output logic [31:0]   host_rdata_o,
  input  logic [AW+1:0] eng_baddr_i,
  input  logic          eng_we_i,
  input  logic          eng_two_i,
  input  logic [15:0]   eng_wdata_i,
  output logic [15:0]   eng_rdata_o
);
  logic [AW-1:0] eng_word;
  logic [1:0]    lane0, lane1;
  logic [7:0]    eng_lane [4];

  assign eng_word = eng_baddr_i[AW+1:2];
  assign lane0    = eng_baddr_i[1:0];
  assign lane1    = lane0 + 2'd1;

  // lane l holds bits 31-8l..24-8l of each word (big-endian packing)
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic       hit0, hit1;
    assign hit0 = (lane0 == 2'(l));
    assign hit1 = eng_two_i && (lane1 == 2'(l));

    always_ff @(posedge clk_i) begin
      if (host_we_i) begin
        if (32'(host_addr_i) < WORDS) mem[host_addr_i] <= host_wdata_i[31-8*l -: 8];
      end else if (eng_we_i && (32'(eng_word) < WORDS)) begin
        if (hit0)      mem[eng_word] <= eng_wdata_i[7:0];
        else if (hit1) mem[eng_word] <= eng_wdata_i[15:8];
      end
    end

    assign host_rdata_o[31-8*l -: 8] = mem[host_addr_i];
    assign eng_lane[l] = mem[eng_word];
  end

  assign eng_rdata_o = {eng_lane[lane1], eng_lane[lane0]};
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int T_LO        = 2,
  parameter int T_HI        = 2,
  parameter int TIMEOUT_CYC = 100000,
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  localparam int BUF_BYTES  = PAGE_BYTES + SPARE_BYTES,
  localparam int BUF_WORDS  = (BUF_BYTES + 3) / 4,
  localparam int AW         = $clog2(BUF_WORDS),
  localparam int LW         = $clog2(BUF_BYTES + 1),
  localparam int TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [7:0]        cmd1_i,
  input  logic [7:0]        cmd2_i,
  input  logic [7:0]        cmd3_i,
  input  logic [15:0]       col_i,
  input  logic [23:0]       row_i,
  input  logic [LW-1:0]     xfer_len_i,
  input  logic              wide_i,
  input  logic              buf_we_i,
  input  logic [AW-1:0]     buf_addr_i,
  input  logic [31:0]       buf_wdata_i,
  output logic [31:0]       buf_rdata_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [15:0]       io_o,
  output logic              io_oe_o,
  input  logic [15:0]       io_i,
  input  logic              rb_ni,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_st_e           st_q;
  logic [CODE_W-1:0] pend_q;
  logic [7:0]        cmd1_q, cmd2_q, cmd3_q;
  logic [15:0]       col_q;
  logic [23:0]       row_q;
  logic [LW-1:0]     len_q;
  logic              wide_q;
  logic [LW:0]       bidx_q, bnext;
  logic [TW-1:0]     rb_cnt_q;
  logic              done_q, err_q;
  logic [15:0]       io_q;
  logic              cle_q, ale_q, rd_q;

  logic [3:0]  ph;
  logic        any;
  ph_kind_t    kind;
  logic [7:0]  cyc_byte;
  logic        multi, last, zero_len, go;
  logic [1:0]  step;
  logic [15:0] drv, eng_rdata;
  logic        sb_low, sb_sample, sb_end, sb_busy;
  logic        eng_we, eng_two;
  logic [AW+1:0] eng_baddr;

  nand_seq_pick #(.W(CODE_W)) u_pick (
    .req_i (pend_q),
    .idx_o (ph),
    .any_o (any)
  );

  always_comb begin
    kind     = '0;
    cyc_byte = 8'h00;
    case (ph)
      B_CMD1:  begin kind.cmd  = 1'b1; cyc_byte = cmd1_q;        end
      B_COL0:  begin kind.addr = 1'b1; cyc_byte = col_q[7:0];    end
      B_COL1:  begin kind.addr = 1'b1; cyc_byte = col_q[15:8];   end
      B_ROW0:  begin kind.addr = 1'b1; cyc_byte = row_q[7:0];    end
      B_ROW1:  begin kind.addr = 1'b1; cyc_byte = row_q[15:8];   end
      B_ROW2:  begin kind.addr = 1'b1; cyc_byte = row_q[23:16];  end
      B_WDAT:  kind.wr = 1'b1;
      B_CMD2:  begin kind.cmd  = 1'b1; cyc_byte = cmd2_q;        end
      B_RBW:   kind.rbw = 1'b1;
      B_RDAT:  kind.rd = 1'b1;
      B_CMD3:  begin kind.cmd  = 1'b1; cyc_byte = cmd3_q;        end
      B_STAT:  kind.stat = 1'b1;
      B_ID:    kind.id = 1'b1;
      default: kind = '0;
    endcase
  end

  assign multi    = kind.wr | kind.rd | kind.id;
  assign step     = (wide_q && (kind.wr || kind.rd)) ? 2'd2 : 2'd1;
  assign bnext    = bidx_q + {{(LW-1){1'b0}}, step};
  assign last     = (bnext >= {1'b0, len_q});
  assign zero_len = multi && (len_q == '0);
  assign go       = (st_q == ST_RUN) && any && !kind.rbw && !zero_len && !sb_busy;

  assign eng_baddr = kind.stat ? '0 : bidx_q[AW+1:0];
  assign eng_we    = sb_sample && rd_q && (st_q == ST_RUN);
  assign eng_two   = wide_q && kind.rd;

  always_comb begin
    if (kind.wr) drv = wide_q ? eng_rdata : {8'h00, eng_rdata[7:0]};
    else         drv = {8'h00, cyc_byte};
  end

  nand_seq_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .low_o    (sb_low),
    .sample_o (sb_sample),
    .end_o    (sb_end),
    .busy_o   (sb_busy)
  );

  nand_seq_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk_i        (clk_i),
    .host_we_i    (buf_we_i),
    .host_addr_i  (buf_addr_i),
    .host_wdata_i (buf_wdata_i),
    .host_rdata_o (buf_rdata_o),
    .eng_baddr_i  (eng_baddr),
    .eng_we_i     (eng_we),
    .eng_two_i    (eng_two),
    .eng_wdata_i  (io_i),
    .eng_rdata_o  (eng_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pend_q   <= '0;
      cmd1_q   <= '0;
      cmd2_q   <= '0;
      cmd3_q   <= '0;
      col_q    <= '0;
      row_q    <= '0;
      len_q    <= '0;
      wide_q   <= 1'b0;
      bidx_q   <= '0;
      rb_cnt_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      io_q     <= '0;
      cle_q    <= 1'b0;
      ale_q    <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            pend_q <= code_i & CODE_MASK;
            cmd1_q <= cmd1_i;
            cmd2_q <= cmd2_i;
            cmd3_q <= cmd3_i;
            col_q  <= col_i;
            row_q  <= row_i;
            len_q  <= xfer_len_i;
            wide_q <= wide_i;
            bidx_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!any) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (kind.rbw) begin
            rb_cnt_q <= '0;
            st_q     <= ST_WAIT;
          end else if (zero_len) begin
            pend_q[ph] <= 1'b0;
          end else begin
            if (go) begin
              io_q  <= drv;
              cle_q <= kind.cmd;
              ale_q <= kind.addr;
              rd_q  <= kind.rd | kind.stat | kind.id;
            end
            if (sb_end) begin
              if (!multi || last) begin
                pend_q[ph] <= 1'b0;
                bidx_q     <= '0;
              end else begin
                bidx_q <= bnext;
              end
            end
          end
        end
        ST_WAIT: begin
          // readiness is checked before expiry
          if (rb_ni) begin
            pend_q[B_RBW] <= 1'b0;
            st_q          <= ST_RUN;
          end else if (rb_cnt_q == TW'(TIMEOUT_CYC - 1)) begin
            err_q  <= 1'b1;
            pend_q <= '0;
            st_q   <= ST_RUN;
          end else begin
            rb_cnt_q <= rb_cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cle_o   = sb_busy & cle_q;
  assign ale_o   = sb_busy & ale_q;
  assign we_no   = ~(sb_low & ~rd_q);
  assign re_no   = ~(sb_low & rd_q);
  assign io_o    = io_q;
  assign io_oe_o = sb_busy & ~rd_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R3
  cle_ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  // R11
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((pend_q & ~$past(pend_q)) == '0));
  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R10
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(st_q) == ST_WAIT) && !$past(rb_ni));
  // R7
  oe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> re_no);
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  localparam int CLK_P = 10;
  localparam int TLO = 2;
  localparam int THI = 2;
  localparam int TMO = 60;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        start_i = 1'b0;
  logic [15:0] code_i = '0;
  logic [7:0]  cmd1_i = '0, cmd2_i = '0, cmd3_i = '0;
  logic [15:0] col_i = '0;
  logic [23:0] row_i = '0;
  logic [11:0] xfer_len_i = '0;
  logic        wide_i = 1'b0;
  logic        buf_we_i = 1'b0;
  logic [9:0]  buf_addr_i = '0;
  logic [31:0] buf_wdata_i = '0;
  logic [31:0] buf_rdata_o;
  logic        cle_o, ale_o, we_no, re_no, io_oe_o, busy_o, done_o, err_o;
  logic [15:0] io_o;
  logic [15:0] io_in = '0;
  logic        rb_q = 1'b1;
  logic        hold_busy = 1'b0;
  logic        rb_w;
  assign rb_w = rb_q & ~hold_busy;

  nand_seq #(.T_LO(TLO), .T_HI(THI), .TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .code_i(code_i),
    .cmd1_i(cmd1_i), .cmd2_i(cmd2_i), .cmd3_i(cmd3_i), .col_i(col_i), .row_i(row_i),
    .xfer_len_i(xfer_len_i), .wide_i(wide_i), .buf_we_i(buf_we_i),
    .buf_addr_i(buf_addr_i), .buf_wdata_i(buf_wdata_i), .buf_rdata_o(buf_rdata_o),
    .cle_o(cle_o), .ale_o(ale_o), .we_no(we_no), .re_no(re_no), .io_o(io_o),
    .io_oe_o(io_oe_o), .io_i(io_in), .rb_ni(rb_w), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [1:0]  lk [0:63];
  logic [15:0] lv [0:63];
  int ln = 0;
  int rd_ptr = 0;
  logic [7:0] rd_base = 8'h00;
  time t_we_f = 0, t_re_f = 0, w_we = 0, w_re = 0, t_re_first = 0, t_rb_rise = 0;

  // flash model: log write-strobe cycles (1 cmd, 2 addr, 3 data)
  always @(posedge we_no) begin
    if (rst_ni) begin
      if (ln < 64) begin
        lk[ln] = cle_o ? 2'd1 : (ale_o ? 2'd2 : 2'd3);
        lv[ln] = io_o;
      end
      ln++;
      w_we = $time - t_we_f;
      if (cle_o && (io_o[7:0] == 8'h30 || io_o[7:0] == 8'h10)) begin
        #1 rb_q = 1'b0;
        repeat (20) @(posedge clk);
        #1 rb_q = 1'b1;
        t_rb_rise = $time;
      end
    end
  end
  always @(negedge we_no) if (rst_ni) t_we_f = $time;
  always @(negedge re_no) begin
    if (rst_ni) begin
      t_re_f = $time;
      if (rd_ptr == 0) t_re_first = $time;
      #1 io_in = {8'hFF, rd_base + 8'(rd_ptr)};
      rd_ptr++;
    end
  end
  always @(posedge re_no) if (rst_ni) w_re = $time - t_re_f;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic chk_log(input string r, input int i, input logic [1:0] k, input logic [15:0] v);
    chk(r, {14'h0, lk[i], lv[i]}, {14'h0, k, v});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk("R12 done timeout", 32'd0, 32'd1);
  endtask

  task automatic run_op(input logic [15:0] code, input logic [7:0] c1, input logic [7:0] c2,
                        input logic [7:0] c3, input logic [15:0] col, input logic [23:0] row,
                        input int len, input logic wd);
    ln = 0;
    rd_ptr = 0;
    @(negedge clk);
    code_i = code; cmd1_i = c1; cmd2_i = c2; cmd3_i = c3;
    col_i = col; row_i = row; xfer_len_i = 12'(len); wide_i = wd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
  endtask

  task automatic wr_word(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    buf_we_i = 1'b1; buf_addr_i = a; buf_wdata_i = d;
    @(negedge clk);
    buf_we_i = 1'b0;
  endtask

  task automatic rd_word(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    buf_addr_i = a;
    #1 d = buf_rdata_o;
  endtask

  task automatic t_reset();
    chk("R1 we_no", 32'(we_no), 32'd1);
    chk("R1 re_no", 32'(re_no), 32'd1);
    chk("R1 cle/ale/oe", {29'h0, cle_o, ale_o, io_oe_o}, 32'd0);
    chk("R1 busy/done/err", {29'h0, busy_o, done_o, err_o}, 32'd0);
  endtask

  task automatic t_page_read();
    logic [31:0] w;
    rd_base = 8'hA0;
    run_op(16'h7EE0, 8'h00, 8'h30, 8'h00, 16'h0123, 24'h456789, 8, 1'b0);
    chk("R2 cycle count read", 32'(ln), 32'd7);
    chk_log("R3 cmd A", 0, 2'd1, 16'h0000);
    chk_log("R4 col low", 1, 2'd2, 16'h0023);
    chk_log("R4 col high", 2, 2'd2, 16'h0001);
    chk_log("R4 row low", 3, 2'd2, 16'h0089);
    chk_log("R4 row mid", 4, 2'd2, 16'h0067);
    chk_log("R4 row high", 5, 2'd2, 16'h0045);
    chk_log("R3 cmd B", 6, 2'd1, 16'h0030);
    chk("R6 read pulses", 32'(rd_ptr), 32'd8);
    chk("R9 read after ready", 32'(t_re_first > t_rb_rise), 32'd1);
    chk("R13 we low width", 32'(w_we), 32'(TLO*CLK_P));
    chk("R13 re low width", 32'(w_re), 32'(TLO*CLK_P));
    rd_word(10'd0, w);
    chk("R6 word0", w, 32'hA0A1A2A3);
    rd_word(10'd1, w);
    chk("R6 word1", w, 32'hA4A5A6A7);
    chk("R12 done/err", {30'h0, done_o, err_o}, 32'd2);
  endtask

  task automatic t_prog_wide();
    wr_word(10'd0, 32'h11223344);
    wr_word(10'd1, 32'h55667788);
    run_op(16'h7DC0, 8'h80, 8'h10, 8'h00, 16'h0840, 24'h000102, 6, 1'b1);
    chk("R2 cycle count prog", 32'(ln), 32'd9);
    chk_log("R7 cmd upper zero", 0, 2'd1, 16'h0080);
    chk_log("R4 addr", 1, 2'd2, 16'h0040);
    chk_log("R4 addr", 2, 2'd2, 16'h0008);
    chk_log("R4 addr", 3, 2'd2, 16'h0002);
    chk_log("R4 addr", 4, 2'd2, 16'h0001);
    chk_log("R5 R7 data0", 5, 2'd3, 16'h2211);
    chk_log("R5 R7 data1", 6, 2'd3, 16'h4433);
    chk_log("R5 R7 data2", 7, 2'd3, 16'h6655);
    chk_log("R3 cmd B", 8, 2'd1, 16'h0010);
  endtask

  task automatic t_status();
    logic [31:0] w;
    rd_base = 8'hE0;
    run_op(16'h4008, 8'h70, 8'h00, 8'h00, 16'h0, 24'h0, 0, 1'b1);
    chk("R8 status cycles", 32'(ln), 32'd1);
    chk("R8 status pulses", 32'(rd_ptr), 32'd1);
    rd_word(10'd0, w);
    chk("R8 status byte0", w, 32'hE0223344);
  endtask

  task automatic t_id();
    logic [31:0] w;
    rd_base = 8'h2C;
    run_op(16'h6004, 8'h90, 8'h00, 8'h00, 16'h0, 24'h0, 5, 1'b1);
    chk_log("R8 id cmd", 0, 2'd1, 16'h0090);
    chk_log("R8 id addr", 1, 2'd2, 16'h0000);
    chk("R8 id pulses", 32'(rd_ptr), 32'd5);
    rd_word(10'd0, w);
    chk("R8 id word0", w, 32'h2C2D2E2F);
    rd_word(10'd1, w);
    chk("R8 id word1", w, 32'h30667788);
  endtask

  task automatic t_order();
    run_op(16'h4090, 8'h01, 8'h02, 8'h03, 16'h0, 24'h0, 0, 1'b0);
    chk("R2 three cmds", 32'(ln), 32'd3);
    chk_log("R2 order A", 0, 2'd1, 16'h0001);
    chk_log("R2 order B", 1, 2'd1, 16'h0002);
    chk_log("R2 order C", 2, 2'd1, 16'h0003);
    run_op(16'h2013, 8'h00, 8'h00, 8'h03, 16'h00AB, 24'h0, 0, 1'b0);
    chk("R2 skip count", 32'(ln), 32'd2);
    chk_log("R2 addr before cmd C", 0, 2'd2, 16'h00AB);
    chk_log("R2 cmd C last", 1, 2'd1, 16'h0003);
  endtask

  task automatic t_zero_len();
    run_op(16'h4020, 8'h05, 8'h00, 8'h00, 16'h0, 24'h0, 0, 1'b0);
    chk("R5 zero length cycles", 32'(ln), 32'd1);
    chk("R5 zero length pulses", 32'(rd_ptr), 32'd0);
  endtask

  task automatic t_timeout();
    hold_busy = 1'b1;
    run_op(16'h4050, 8'hFF, 8'h00, 8'h03, 16'h0, 24'h0, 0, 1'b0);
    chk("R10 err/done", {30'h0, done_o, err_o}, 32'd3);
    chk("R10 rest dropped", 32'(ln), 32'd1);
    chk_log("R10 only cmd A", 0, 2'd1, 16'h00FF);
    hold_busy = 1'b0;
    run_op(16'h4000, 8'h06, 8'h00, 8'h00, 16'h0, 24'h0, 0, 1'b0);
    chk("R12 err cleared by start", 32'(err_o), 32'd0);
  endtask

  task automatic t_busy_start();
    bit hit = 1'b0;
    rd_base = 8'h40;
    ln = 0;
    rd_ptr = 0;
    @(negedge clk);
    code_i = 16'h7EE0; cmd1_i = 8'h00; cmd2_i = 8'h30; cmd3_i = 8'h00;
    col_i = 16'h0; row_i = 24'h0; xfer_len_i = 12'd4; wide_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    code_i = 16'h0010; cmd3_i = 8'h5A;
    for (int n = 0; n < 20000; n++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R11 done after overlap", 32'(done_o), 32'd1);
    @(negedge clk);
    chk("R12 done sticky", 32'(done_o), 32'd1);
    chk("R11 cycle count", 32'(ln), 32'd7);
    for (int i = 0; i < 7 && i < 64; i++) if (lv[i] == 16'h005A) hit = 1'b1;
    chk("R11 no second opcode", 32'(hit), 32'd0);
  endtask

  initial begin
    #(CLK_P*190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_page_read();
    t_prog_wide();
    t_status();
    t_id();
    t_order();
    t_zero_len();
    t_timeout();
    t_busy_start();
    summary();
    $finish;
  end
endmodule